// File: doc/BRIEF.md
# Register Redirection Tag Table

This block sits between instruction decode and issue. It holds a small table of tag entries. Each entry redirects one 5-bit architectural register number, within either the integer or the floating-point register file, to a 7-bit physical register number. A 7-bit number reaches 128 registers. Each entry also marks the target as vector or scalar and carries an element-width override. Every cycle the table looks up the rs1, rs2 and rd operands of the current instruction in parallel. It reports the redirected register, the vector flag, the width override and a hit flag for each operand. It also raises a loop-start flag whenever any operand lands on a vector target.

Entries arrive one per cycle through a write port and use either a compact 8-bit form or a full 16-bit form. A small controller walks through three states:

- `ST_IDLE`: the state after reset. The table is empty.
- `ST_FILL`: entries are being loaded.
- `ST_ARMED`: the table is live and lookups use it.

The transitions are:

- `load_start` takes any state to `ST_FILL` and clears the table. It has priority over every other input.
- `load_done` takes `ST_FILL` to `ST_ARMED`.

In all other cases the state holds. Outside `ST_ARMED` every operand passes through untouched. A predicate tag on rd is honoured only when rd itself hit a redirection entry.

Top module: `reg_redirect_table`

## Requirements
- R1: After reset `armed` is 0, and every lookup passes through as a miss. The physical number is the zero-extended architectural number, with vec=0, ew=00 and hit=0.
- R2: Control flow:
  - `load_start` puts the controller in ST_FILL from the next cycle and empties the table. It wins over `load_done` and over `wr_en` in the same cycle.
  - `load_done` in ST_FILL moves to ST_ARMED (`armed`=1) from the next cycle.
  - `load_done` in ST_IDLE or ST_ARMED has no effect.
  - Lookups miss in ST_IDLE and ST_FILL.
- R3: A lookup hits only when both the 5-bit register number and the integer/float selector match an entry. `is_int`=1 selects the integer file and 0 selects the floating-point file.
- R4: In the 16-bit form (`wr_fmt`=1), the fields of `wr_data` are:
  - bits 4:0: the key register.
  - bit 5: the integer/float selector (1 = integer).
  - bits 7:6: the width override.
  - bits 14:8: the 7-bit target.
  - bit 15: scalar when 1 and vector when 0.
- R5: In the 8-bit form (`wr_fmt`=0), only bits 7:0 are used, with the same low-byte layout as R4. The target is the key register shifted left by two, and the entry is always vector. Bits 15:8 are ignored.
- R6: On a hit, the width override of the entry appears on the operand's `ew` output. The codes are 00 for default width, 01 for 8 bits, 10 for 16 bits and 11 for 32 bits. A miss gives 00.
- R7: On a miss, the operand's physical number is its 5-bit number zero-extended to 7 bits, with vec=0 and hit=0.
- R8: When two stored entries share a key, the one written later decides the lookup result.
- R9: The table holds 16 entries. Writes after the sixteenth in one fill are ignored.
- R10: `loop_go` is 1 exactly when at least one of the three operands hits an entry whose vec flag is 1. Hits on scalar entries alone leave it 0.
- R11: `pred_rd_use` is 1 exactly when `pred_rd_tag` is 1 and rd hits.
- R12: `wr_en` outside ST_FILL has no effect on the table.
- R13: rs1, rs2 and rd are looked up independently in the same cycle, all against the one `is_int` selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Clear the table and enter fill |
| load_done | input | 1 | End of fill; arm the table |
| wr_en | input | 1 | Write one entry this cycle |
| wr_fmt | input | 1 | 1 = 16-bit entry form, 0 = 8-bit entry form |
| wr_data | input | 16 | Entry bits |
| is_int | input | 1 | 1 = integer operands, 0 = floating-point operands |
| rs1 | input | 5 | Source 1 register number |
| rs2 | input | 5 | Source 2 register number |
| rd | input | 5 | Destination register number |
| pred_rd_tag | input | 1 | A predicate entry exists for rd |
| rs1_phys | output | 7 | Redirected source 1 |
| rs1_vec | output | 1 | Source 1 is vector |
| rs1_ew | output | 2 | Source 1 width override |
| rs1_hit | output | 1 | Source 1 matched an entry |
| rs2_phys | output | 7 | Redirected source 2 |
| rs2_vec | output | 1 | Source 2 is vector |
| rs2_ew | output | 2 | Source 2 width override |
| rs2_hit | output | 1 | Source 2 matched an entry |
| rd_phys | output | 7 | Redirected destination |
| rd_vec | output | 1 | Destination is vector |
| rd_ew | output | 2 | Destination width override |
| rd_hit | output | 1 | Destination matched an entry |
| loop_go | output | 1 | Start the element loop |
| pred_rd_use | output | 1 | Apply predication to rd |
| armed | output | 1 | Table is live |

## Verification
Lookups are combinational from stored state, so a corrupted slot, valid bit or fill counter shows on the operand outputs in the same cycle that a key reaches it. A wrong controller state shows one cycle after the edge that caused it, as a wrong `armed` value and as hits that should be misses, or the reverse. A bad fill counter shows up in one of two ways. It can lose the latest-wins order among duplicate keys, which shows on the first lookup of that key after arming. It can let a seventeenth write land, which shows on the first lookup of that write's key.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    localparam int ARCH_W = 5;
    localparam int PHYS_W = 7;
    localparam int EW_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_ARMED = 2'd2
    } rrt_state_e;

    typedef struct packed {
        logic [ARCH_W-1:0] key;
        logic              isint;
        logic [PHYS_W-1:0] tgt;
        logic              vec;
        logic [EW_W-1:0]   ew;
    } rrt_entry_t;
endpackage

// File: rtl/rrt_entry_decode.sv
module rrt_entry_decode
    import rrt_pkg::*;
(
    input  logic        fmt16,
    input  logic [15:0] raw,
    output rrt_entry_t  ent
);
    localparam int SHIFT = PHYS_W - ARCH_W;

    always_comb begin
        ent.key   = raw[ARCH_W-1:0];
        ent.isint = raw[5];
        ent.ew    = raw[7:6];
        if (fmt16) begin
            ent.tgt = raw[14:8];
            ent.vec = ~raw[15];
        end else begin
            ent.tgt = {raw[ARCH_W-1:0], {SHIFT{1'b0}}};
            ent.vec = 1'b1;
        end
    end
endmodule

// File: rtl/rrt_ctrl.sv
module rrt_ctrl
    import rrt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_start,
    input  logic             load_done,
    input  logic             wr_en,
    output logic             clear,
    output logic             wr_go,
    output logic [IDX_W-1:0] wr_idx,
    output logic             armed
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    rrt_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (load_start) nxt = ST_FILL;
            ST_FILL:  if (load_start) nxt = ST_FILL;
                      else if (load_done) nxt = ST_ARMED;
            ST_ARMED: if (load_start) nxt = ST_FILL;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (load_start)
                cnt <= '0;
            else if (wr_go)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        clear  = load_start;
        wr_go  = (state == ST_FILL) && wr_en && !load_start && (cnt < FULL);
        wr_idx = cnt[IDX_W-1:0];
        armed  = (state == ST_ARMED);
    end
endmodule

// File: rtl/rrt_lookup.sv
module rrt_lookup
    import rrt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  rrt_entry_t        ents [DEPTH],
    input  logic [DEPTH-1:0]  valid,
    input  logic              enable,
    input  logic [ARCH_W-1:0] key,
    input  logic              isint,
    output logic [PHYS_W-1:0] phys,
    output logic              vec,
    output logic [EW_W-1:0]   ew,
    output logic              hit
);
    rrt_entry_t sel;
    logic       found;

    // ascending scan: the highest matching slot (latest write) wins
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid[i] && ents[i].key == key && ents[i].isint == isint) begin
                found = 1'b1;
                sel   = ents[i];
            end
        end
    end

    always_comb begin
        hit = enable && found;
        if (hit) begin
            phys = sel.tgt;
            vec  = sel.vec;
            ew   = sel.ew;
        end else begin
            phys = {{(PHYS_W-ARCH_W){1'b0}}, key};
            vec  = 1'b0;
            ew   = '0;
        end
    end
endmodule

// File: rtl/reg_redirect_table.sv
module reg_redirect_table
    import rrt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_start,
    input  logic        load_done,
    input  logic        wr_en,
    input  logic        wr_fmt,
    input  logic [15:0] wr_data,
    input  logic        is_int,
    input  logic [4:0]  rs1,
    input  logic [4:0]  rs2,
    input  logic [4:0]  rd,
    input  logic        pred_rd_tag,
    output logic [6:0]  rs1_phys,
    output logic        rs1_vec,
    output logic [1:0]  rs1_ew,
    output logic        rs1_hit,
    output logic [6:0]  rs2_phys,
    output logic        rs2_vec,
    output logic [1:0]  rs2_ew,
    output logic        rs2_hit,
    output logic [6:0]  rd_phys,
    output logic        rd_vec,
    output logic [1:0]  rd_ew,
    output logic        rd_hit,
    output logic        loop_go,
    output logic        pred_rd_use,
    output logic        armed
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int NOPS  = 3;

    logic             clear, wr_go;
    logic [IDX_W-1:0] wr_idx;
    rrt_entry_t       dec;
    rrt_entry_t       ents [DEPTH];
    logic [DEPTH-1:0] valid;

    rrt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_done(load_done),
        .wr_en(wr_en), .clear(clear), .wr_go(wr_go), .wr_idx(wr_idx), .armed(armed)
    );

    rrt_entry_decode u_dec (.fmt16(wr_fmt), .raw(wr_data), .ent(dec));

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                valid[s] <= 1'b0;
                ents[s]  <= '0;
            end else if (wr_go && wr_idx == IDX_W'(s)) begin
                valid[s] <= 1'b1;
                ents[s]  <= dec;
            end
        end
    end

    logic [ARCH_W-1:0] op_key  [NOPS];
    logic [PHYS_W-1:0] op_phys [NOPS];
    logic [EW_W-1:0]   op_ew   [NOPS];
    logic [NOPS-1:0]   op_vec, op_hit;

    assign op_key[0] = rs1;
    assign op_key[1] = rs2;
    assign op_key[2] = rd;

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        rrt_lookup #(.DEPTH(DEPTH)) u_lk (
            .ents(ents), .valid(valid), .enable(armed), .key(op_key[k]), .isint(is_int),
            .phys(op_phys[k]), .vec(op_vec[k]), .ew(op_ew[k]), .hit(op_hit[k])
        );
    end

    always_comb begin
        rs1_phys    = op_phys[0]; rs1_vec = op_vec[0]; rs1_ew = op_ew[0]; rs1_hit = op_hit[0];
        rs2_phys    = op_phys[1]; rs2_vec = op_vec[1]; rs2_ew = op_ew[1]; rs2_hit = op_hit[1];
        rd_phys     = op_phys[2]; rd_vec  = op_vec[2]; rd_ew  = op_ew[2]; rd_hit  = op_hit[2];
        loop_go     = |(op_hit & op_vec);
        pred_rd_use = pred_rd_tag && op_hit[2];
    end
endmodule

// File: rtl/reg_redirect_table_chk.sv
module reg_redirect_table_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load_start,
    input logic       load_done,
    input logic [4:0] rs1,
    input logic [6:0] rs1_phys,
    input logic       rs1_vec,
    input logic       rs1_hit,
    input logic       rs2_hit,
    input logic       rd_hit,
    input logic       pred_rd_tag,
    input logic       loop_go,
    input logic       pred_rd_use,
    input logic       armed
);
    // R2
    start_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> !armed);

    // R2
    arm_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(load_done));

    // R2
    no_hit_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !(rs1_hit || rs2_hit || rd_hit));

    // R7
    miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs1_hit |-> (rs1_phys == {2'b00, rs1} && !rs1_vec));

    // R10
    loop_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_go |-> (rs1_hit || rs2_hit || rd_hit));

    // R11
    pred_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_rd_use |-> (rd_hit && pred_rd_tag));
endmodule

bind reg_redirect_table reg_redirect_table_chk u_chk (.*);

// File: tb/reg_redirect_table_test.sv
module reg_redirect_table_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, load_start, load_done, wr_en, wr_fmt, is_int, pred_rd_tag;
    logic [15:0] wr_data;
    logic [4:0]  rs1, rs2, rd;
    logic [6:0]  rs1_phys, rs2_phys, rd_phys;
    logic        rs1_vec, rs2_vec, rd_vec, rs1_hit, rs2_hit, rd_hit;
    logic [1:0]  rs1_ew, rs2_ew, rd_ew;
    logic        loop_go, pred_rd_use, armed;

    reg_redirect_table uut (.*);

    int vectors = 0;
    int errs = 0;

    // behavioural model
    int m_state = 0;   // 0 idle, 1 fill, 2 armed
    int m_key[$];
    bit m_int[$];
    int m_tgt[$];
    bit m_vec[$];
    int m_ew[$];

    task automatic mlook(input int r, input bit ii, output int ph, output bit v,
                         output int e, output bit h);
        ph = r; v = 0; e = 0; h = 0;
        if (m_state == 2)
            for (int i = m_key.size() - 1; i >= 0; i--)
                if (m_key[i] == r && m_int[i] == ii) begin
                    ph = m_tgt[i]; v = m_vec[i]; e = m_ew[i]; h = 1;
                    break;
                end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        int ph[3]; bit v[3]; int e[3]; bit h[3];
        int regs[3];
        bit lg;
        regs[0] = rs1; regs[1] = rs2; regs[2] = rd;
        for (int k = 0; k < 3; k++) mlook(regs[k], is_int, ph[k], v[k], e[k], h[k]);
        lg = (h[0] && v[0]) || (h[1] && v[1]) || (h[2] && v[2]);
        vectors++;
        chk(tag, "armed", armed, m_state == 2);
        chk(tag, "rs1_phys", rs1_phys, ph[0]); chk(tag, "rs1_vec", rs1_vec, v[0]);
        chk(tag, "rs1_ew", rs1_ew, e[0]);      chk(tag, "rs1_hit", rs1_hit, h[0]);
        chk(tag, "rs2_phys", rs2_phys, ph[1]); chk(tag, "rs2_vec", rs2_vec, v[1]);
        chk(tag, "rs2_ew", rs2_ew, e[1]);      chk(tag, "rs2_hit", rs2_hit, h[1]);
        chk(tag, "rd_phys", rd_phys, ph[2]);   chk(tag, "rd_vec", rd_vec, v[2]);
        chk(tag, "rd_ew", rd_ew, e[2]);        chk(tag, "rd_hit", rd_hit, h[2]);
        chk(tag, "loop_go", loop_go, lg);
        chk(tag, "pred_rd_use", pred_rd_use, pred_rd_tag && h[2]);
    endtask

    task automatic mupdate();
        if (load_start) begin
            m_state = 1;
            m_key.delete(); m_int.delete(); m_tgt.delete(); m_vec.delete(); m_ew.delete();
        end else begin
            if (m_state == 1 && wr_en && m_key.size() < 16) begin
                m_key.push_back(wr_data[4:0]);
                m_int.push_back(wr_data[5]);
                m_ew.push_back(wr_data[7:6]);
                if (wr_fmt) begin
                    m_tgt.push_back(wr_data[14:8]);
                    m_vec.push_back(!wr_data[15]);
                end else begin
                    m_tgt.push_back(wr_data[4:0] * 4);
                    m_vec.push_back(1'b1);
                end
            end
            if (m_state == 1 && load_done) m_state = 2;
        end
    endtask

    // inputs are set just after a falling edge; compare 1 ns later, then step
    task automatic cyc(string tag);
        #1;
        compare(tag);
        mupdate();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] e16(int r, bit ii, int ew, int tgt, bit scalar);
        return {scalar, 7'(tgt), 2'(ew), ii, 5'(r)};
    endfunction

    function automatic logic [15:0] e8(int r, bit ii, int ew, int junk);
        return {8'(junk), 2'(ew), ii, 5'(r)};
    endfunction

    task automatic wr(bit fmt, logic [15:0] d, string tag);
        wr_en = 1; wr_fmt = fmt; wr_data = d;
        cyc(tag);
        wr_en = 0;
    endtask

    task automatic look(bit ii, int a, int b, int c, string tag);
        is_int = ii; rs1 = 5'(a); rs2 = 5'(b); rd = 5'(c);
        cyc(tag);
    endtask

    initial begin
        #2000000;
        errs++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        rst_n = 0; load_start = 0; load_done = 0; wr_en = 0; wr_fmt = 0; wr_data = 0;
        is_int = 1; rs1 = 3; rs2 = 5; rd = 9; pred_rd_tag = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1 reset state: everything passes through
        look(1, 3, 5, 9, "R1");
        look(0, 31, 0, 17, "R1");
        // R2 load_done in idle is ignored
        load_done = 1; cyc("R2"); load_done = 0;
        look(1, 3, 5, 9, "R2");
        // R2 enter fill
        load_start = 1; cyc("R2"); load_start = 0;
        wr(1, e16(3, 1, 1, 100, 0), "R4");
        wr(0, e8(5, 0, 3, 8'hFF), "R5");
        wr(1, e16(9, 1, 2, 77, 1), "R4");
        wr(0, e8(7, 1, 0, 8'h5A), "R5");
        // R2 fill still passes through
        look(1, 3, 9, 7, "R2");
        load_done = 1; cyc("R2"); load_done = 0;
        // R13 all three at once
        look(1, 3, 9, 7, "R13");
        // R3 selector matters
        look(0, 3, 5, 9, "R3");
        look(1, 5, 4, 8, "R3");
        // R10 only scalar hit -> no loop
        look(1, 9, 1, 2, "R10");
        look(1, 1, 2, 9, "R10");
        // R11 predicate gating
        pred_rd_tag = 1;
        look(1, 0, 0, 3, "R11");
        look(1, 0, 0, 4, "R11");
        pred_rd_tag = 0;
        // R12 writes while armed are ignored
        wr(1, e16(4, 1, 1, 55, 0), "R12");
        look(1, 4, 4, 4, "R12");
        // R2 load_done while armed ignored
        load_done = 1; cyc("R2"); load_done = 0;
        look(1, 3, 3, 3, "R2");
        // R2 start beats write and done
        load_start = 1; load_done = 1; wr_en = 1; wr_fmt = 1; wr_data = e16(2, 1, 1, 66, 0);
        cyc("R2");
        load_start = 0; load_done = 0; wr_en = 0;
        // R8 duplicate keys, latest wins
        wr(1, e16(3, 1, 0, 10, 0), "R8");
        wr(1, e16(3, 1, 3, 20, 1), "R8");
        // R9 fill past capacity
        for (int i = 0; i < 16; i++)
            wr(1, e16(10 + i, i % 2, i % 4, 40 + i, 0), "R9");
        load_done = 1; cyc("R2"); load_done = 0;
        look(1, 3, 2, 3, "R8");
        look(1, 2, 2, 2, "R2");
        for (int i = 0; i < 16; i++)
            look(i % 2, 10 + i, 10 + i, 10 + i, "R9");
        // R6 width codes across entries
        look(0, 10, 12, 14, "R6");
        look(1, 11, 13, 15, "R6");
        // R7 misses while armed
        look(1, 0, 31, 30, "R7");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule